// File: doc/BRIEF.md
# SCL Low-Wait Timeout Timer

This block is the watchdog that bounds how long an I2C master engine may sit waiting for the SCL line to be released. A peripheral that stretches the clock by holding SCL low would otherwise stall the engine forever. The engine raises a wait strobe while it needs SCL to go high. Whenever that strobe is set, the sampled SCL is low and the timer is enabled, a prescaled down counter runs. If the counter runs out, the block emits a single-cycle timeout pulse. The engine turns that pulse into its timeout error flag and abandons the transfer.

The control word carries both the enable flag and the reload value. A separate exponent input selects a power-of-two divide of the system clock, and that divided tick steps the counter. Software sizes the value and exponent so that the window lasts a few tens of milliseconds. Any break in the low period restarts the whole window: the wait strobe dropping, SCL being seen high, or the enable being cleared.

All pins are plain control and status signals. No data flows through the block, so it has no valid/ready handshake.

Top module: `scl_wait_timer`

## Requirements
- R1: After reset the timeout pulse output is low. The first wait that follows reset runs the full window.
- R2: The control word places the enable flag at bit 15 and the reload value V at bits 14:0. With exponent p, a wait that stays uninterrupted yields the pulse exactly (V+1)·2^p clocks after the first rising edge that sees the wait active. The pulse is visible in the cycle after that edge.
- R3: The pulse lasts one clock. Only one pulse is produced per wait, however long the wait continues afterwards.
- R4: If SCL is sampled high during a wait, the counter and prescaler reload. Only a low period with no break can expire.
- R5: If the wait strobe drops, both counters reload. The next wait then runs the full (V+1)·2^p window.
- R6: While the enable flag is 0, no pulse is ever produced. Clearing it in the middle of a wait cancels that wait.
- R7: Every exponent from 0 to 15 is honoured, including the extremes. With V = 0, expiry falls on the first divided tick, 2^p clocks into the wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_word_i | input | 16 | Bit 15 enable, bits 14:0 reload value |
| prescale_exp_i | input | 4 | Log2 of the tick divide (0..15) |
| wait_scl_i | input | 1 | Engine is waiting for SCL to go high |
| scl_i | input | 1 | Sampled SCL level |
| timeout_pulse_o | output | 1 | One-cycle expiry pulse |

## Verification
The assertions assume that the exponent and the reload value stay constant for the length of any one wait. Software is expected to program them only while the engine is idle. The stimulus follows this: every scenario sets the configuration while the wait strobe is low and changes it only after that wait has ended. Inputs are also assumed to be synchronous. The bench therefore drives every input on the falling edge, so each rising edge sees stable levels.

// File: rtl/scl_wait_pkg.sv
package scl_wait_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FIRED = 2'd2
  } wait_state_e;

endpackage

// File: rtl/scl_wait_prescaler.sv
module scl_wait_prescaler #(
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic             tick_o
);
  localparam int PRE_W = (1 << EXP_W) - 1;

  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] limit;

  // limit = 2^exp - 1; at exp = PRE_W the shift clears every bit
  assign limit  = ~({PRE_W{1'b1}} << exp_i);
  assign tick_o = run_i && (pre_cnt >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_cnt <= '0;
    end else if (!run_i) begin
      pre_cnt <= '0;
    end else if (tick_o) begin
      pre_cnt <= '0;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  AST_PRE_STARTS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_i) |-> (pre_cnt == '0)); // R5

  AST_PRE_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (pre_cnt == '0)); // R4

endmodule

// File: rtl/scl_wait_counter.sv
module scl_wait_counter
  import scl_wait_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] load_i,
  output logic             expire_o
);
  wait_state_e      state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] eff_cnt;

  // a wait starting this cycle counts from the live reload value
  assign eff_cnt = (state == ST_IDLE) ? load_i : cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      expire_o <= 1'b0;
    end else if (!run_i) begin
      state    <= ST_IDLE;
      cnt      <= load_i;
      expire_o <= 1'b0;
    end else if (state == ST_FIRED) begin
      expire_o <= 1'b0;
    end else if (tick_i && (eff_cnt == '0)) begin
      state    <= ST_FIRED;
      cnt      <= '0;
      expire_o <= 1'b1;
    end else begin
      state    <= ST_RUN;
      cnt      <= tick_i ? eff_cnt - 1'b1 : eff_cnt;
      expire_o <= 1'b0;
    end
  end

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> !expire_o); // R3

  AST_ONE_PER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FIRED && run_i) |=> !expire_o); // R3

  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && run_i && !tick_i) |=> $stable(cnt)); // R2

  AST_RELOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt == $past(load_i))); // R5

endmodule

// File: rtl/scl_wait_timer.sv
module scl_wait_timer #(
  parameter int CNT_W = 15,
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W:0]   ctrl_word_i,
  input  logic [EXP_W-1:0] prescale_exp_i,
  input  logic             wait_scl_i,
  input  logic             scl_i,
  output logic             timeout_pulse_o
);
  localparam int EN_BIT = CNT_W;

  logic             enable;
  logic [CNT_W-1:0] reload;
  logic             run;
  logic             tick;

  assign enable = ctrl_word_i[EN_BIT];
  assign reload = ctrl_word_i[CNT_W-1:0];
  assign run    = enable && wait_scl_i && !scl_i;

  scl_wait_prescaler #(.EXP_W(EXP_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run),
    .exp_i  (prescale_exp_i),
    .tick_o (tick)
  );

  scl_wait_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (run),
    .tick_i   (tick),
    .load_i   (reload),
    .expire_o (timeout_pulse_o)
  );

  AST_NO_PULSE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_word_i[EN_BIT] |=> !timeout_pulse_o); // R6

  AST_PULSE_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse_o |-> $past(wait_scl_i && !scl_i)); // R4

endmodule

// File: tb/scl_wait_timer_tb_top.sv
module scl_wait_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ctrl_word = '0;
  logic [3:0]  pexp = '0;
  logic        wait_scl = 1'b0;
  logic        scl = 1'b1;
  logic        tpulse;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  scl_wait_timer dut_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .ctrl_word_i     (ctrl_word),
    .prescale_exp_i  (pexp),
    .wait_scl_i      (wait_scl),
    .scl_i           (scl),
    .timeout_pulse_o (tpulse)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setup(input bit en, input int v, input int p);
    @(negedge clk);
    wait_scl  = 1'b0;
    scl       = 1'b1;
    ctrl_word = {en, v[14:0]};
    pexp      = p[3:0];
    @(negedge clk);
  endtask

  // runs n edges; pulse expected only after edge fire_at (0 = never);
  // returns the edge count of the first mismatch (0 if none)
  task automatic window(input int n, input int fire_at, output int bad_at);
    bad_at = 0;
    for (int k = 1; k <= n; k++) begin
      @(posedge clk);
      @(negedge clk);
      if ((tpulse !== (k == fire_at)) && bad_at == 0) bad_at = k;
    end
  endtask

  task automatic start_wait();
    wait_scl = 1'b1;
    scl      = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(tpulse === 1'b0, "R1 reset output", tpulse, 0);
  endtask

  task automatic t_timing(input int v, input int p, input string tag);
    int n, bad;
    setup(1'b1, v, p);
    n = (v + 1) << p;
    start_wait();
    window(n + 3, n, bad);
    check(bad == 0, tag, bad, 0);
    wait_scl = 1'b0;
  endtask

  task automatic t_single_pulse();
    int bad;
    setup(1'b1, 3, 1);
    start_wait();
    window(8 + 40, 8, bad);
    check(bad == 0, "R3 single pulse per wait", bad, 0);
    wait_scl = 1'b0;
  endtask

  task automatic t_scl_high();
    int bad;
    setup(1'b1, 2, 1);
    start_wait();
    window(5, 0, bad);
    check(bad == 0, "R4 no pulse before break", bad, 0);
    scl = 1'b1;
    window(1, 0, bad);
    scl = 1'b0;
    window(9, 6, bad);
    check(bad == 0, "R4 window restarts after SCL high", bad, 0);
    wait_scl = 1'b0;
  endtask

  task automatic t_wait_drop();
    int bad;
    setup(1'b1, 4, 2);
    start_wait();
    window(19, 0, bad);
    wait_scl = 1'b0;
    window(2, 0, bad);
    start_wait();
    window(23, 20, bad);
    check(bad == 0, "R5 full window after wait drop", bad, 0);
    wait_scl = 1'b0;
  endtask

  task automatic t_disabled();
    int bad;
    setup(1'b0, 0, 0);
    start_wait();
    window(50, 0, bad);
    check(bad == 0, "R6 disabled never pulses", bad, 0);
    wait_scl = 1'b0;
    setup(1'b1, 3, 1);
    start_wait();
    window(6, 0, bad);
    ctrl_word[15] = 1'b0;
    window(30, 0, bad);
    check(bad == 0, "R6 cleared enable cancels wait", bad, 0);
    wait_scl = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_timing(5, 0, "R1 first wait after reset full length");
    t_timing(0, 0, "R7 value zero exponent zero");
    t_timing(7, 0, "R2 exp0 value7");
    t_timing(2, 3, "R2 exp3 value2");
    t_timing(0, 4, "R7 value zero first tick exp4");
    t_timing(9, 1, "R2 exp1 value9");
    t_timing(0, 15, "R7 exponent fifteen");
    t_timing(1, 2, "R2 exp2 value1");
    t_single_pulse();
    t_scl_high();
    t_wait_drop();
    t_disabled();
    t_timing(3, 0, "R5 enabled again after cancel");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule